// File: doc/BRIEF.md
# Switch Request Gating Timer

This block sits on the secondary side of an isolated flyback converter. It decides when a switching-cycle request may be sent across to the primary. The regulation loop raises a raw request whenever it wants energy. The block holds that request until several timing rules are met, and then emits a single-cycle request pulse. All timing constants are parameters counted in clock cycles.

After a request goes out, the primary is assumed to be conducting. Further requests are locked out until the forward-winding sense comparator reports a falling edge, or until a timeout expires. The end of that on-phase starts the off-time clock. A new request needs a minimum off-time and a minimum spacing from the previous request. A request is also withheld while the off-time lies inside a configurable window of spacings that would put the switching rate in an audible band.

The same block drives the synchronous-rectifier enable. The enable rises on the forward falling edge. In discontinuous mode it falls when the zero-cross flag reports that the rectifier voltage has gone negative. In continuous mode it falls together with the next request.

Top module: `req_pacer`

## Requirements
- R1: A request pulse issued at clock edge X after an on-phase that ended at edge E satisfies X - E >= OFF_MIN.
- R2: Two consecutive request pulses are at least PERIOD_MIN cycles apart.
- R3: After a request pulse issued at edge P, no pulse is issued before the on-phase ends. The on-phase ends at the first later edge that samples fwd_fall high.
- R4: If fwd_fall is not sampled in time, the on-phase ends at edge P + ON_TIMEOUT. A fwd_fall sampled after that, while no request is outstanding, is ignored: it does not restart the off-time and does not raise sr_en.
- R5: No request pulse is issued while the off-time X - E lies in [SKIP_LO, SKIP_HI]. A request blocked only by this window is issued at edge E + SKIP_HI + 1.
- R6: A raw request blocked by any rule stays pending without being held. It is issued at the first edge where every rule is clear.
- R7: req_pulse is registered and lasts exactly one cycle. A request sampled at an edge where all rules are clear gives req_pulse high right after that same edge.
- R8: sr_en goes high right after the edge that ends an on-phase through fwd_fall.
- R9: With ccm_mode = 0, sr_en goes low right after an edge that samples zc_neg high. With ccm_mode = 1, zc_neg has no effect on sr_en.
- R10: sr_en is low in every cycle in which req_pulse is high, so in continuous mode it falls in the same cycle as the pulse.
- R11: Reset drives both outputs low and clears the on-phase lockout. It leaves the off-time and spacing timers expired, so a request made right after reset is issued at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_raw | input | 1 | Request from the regulation loop |
| fwd_fall | input | 1 | One-cycle pulse: falling edge seen on forward-winding sense |
| ccm_mode | input | 1 | 1 = continuous conduction, 0 = discontinuous |
| zc_neg | input | 1 | Rectifier voltage has dropped below zero |
| req_pulse | output | 1 | One-cycle request toward the primary |
| sr_en | output | 1 | Synchronous-rectifier gate enable |

## Verification
The bench uses OFF_MIN = 3, PERIOD_MIN = 8, ON_TIMEOUT = 20 and an audible window of 5 to 7 cycles. With these values, the spacing rule, the off-time rule, the window skip and the timeout each become the deciding constraint for some part of the sweep. The sweep covers every forward-edge delay from 1 to beyond the timeout, every request time from inside the lockout to well past it, and both conduction modes. The pulse position and the rectifier-enable interval are computed arithmetically for every combination.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pacer_gap_timer.sv
// Saturating elapsed-cycle counter. Restart loads 1; reset loads CAP (expired).
module pacer_gap_timer #(
  parameter int unsigned CAP = 16,
  parameter int          CW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CAP_V = CW'(CAP);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)                count <= CAP_V;
    else if (restart)       count <= ONE_V;
    else if (count != CAP_V) count <= count + ONE_V;
  end
endmodule

// File: rtl/pacer_lock.sv
// On-phase tracker: busy from an issued request until fwd_fall or timeout.
module pacer_lock #(
  parameter int unsigned TIMEOUT = 32,
  localparam int         TW      = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fwd_fall,
  output logic busy,
  output logic end_now,
  output logic edge_hit
);
  localparam logic [TW-1:0] LIM = TW'(TIMEOUT);
  logic [TW-1:0] on_cnt;

  assign edge_hit = busy & fwd_fall;
  assign end_now  = busy & (fwd_fall | (on_cnt >= LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      on_cnt <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      on_cnt <= TW'(1);
    end else if (busy) begin
      if (end_now) busy <= 1'b0;
      else         on_cnt <= on_cnt + TW'(1);
    end
  end
endmodule

// File: rtl/pacer_sr_ctl.sv
// Rectifier enable: set on forward edge, cleared on request or (DCM) zero cross.
module pacer_sr_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic issue_i,
  input  logic ccm_mode,
  input  logic zc_neg,
  output logic sr_en
);
  always_ff @(posedge clk) begin
    if (rst)                       sr_en <= 1'b0;
    else if (issue_i)              sr_en <= 1'b0;
    else if (set_i)                sr_en <= 1'b1;
    else if (!ccm_mode && zc_neg)  sr_en <= 1'b0;
  end
endmodule

// File: rtl/req_pacer.sv
module req_pacer
  import pacer_pkg::*;
#(
  parameter int unsigned OFF_MIN    = 200,
  parameter int unsigned PERIOD_MIN = 1000,
  parameter int unsigned ON_TIMEOUT = 3000000,
  parameter int unsigned SKIP_LO    = 8300,
  parameter int unsigned SKIP_HI    = 14300,
  parameter bit          SKIP_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_raw,
  input  logic fwd_fall,
  input  logic ccm_mode,
  input  logic zc_neg,
  output logic req_pulse,
  output logic sr_en
);
  localparam int unsigned CAP = max_u(max_u(OFF_MIN, PERIOD_MIN), SKIP_HI + 1);
  localparam int          CW  = $clog2(CAP + 1);
  localparam logic [CW-1:0] OFF_V = CW'(OFF_MIN);
  localparam logic [CW-1:0] PER_V = CW'(PERIOD_MIN);

  logic [CW-1:0] off_cnt, per_cnt;
  logic busy, end_now, edge_hit;
  logic pend_q, want, in_band, clear_ok, issue;

  pacer_lock #(.TIMEOUT(ON_TIMEOUT)) u_lock (
    .clk(clk), .rst(rst), .start(issue), .fwd_fall(fwd_fall),
    .busy(busy), .end_now(end_now), .edge_hit(edge_hit)
  );

  pacer_gap_timer #(.CAP(CAP), .CW(CW)) u_off (
    .clk(clk), .rst(rst), .restart(end_now), .count(off_cnt)
  );

  pacer_gap_timer #(.CAP(CAP), .CW(CW)) u_per (
    .clk(clk), .rst(rst), .restart(issue), .count(per_cnt)
  );

  generate
    if (SKIP_EN) begin : g_skip
      localparam logic [CW-1:0] LO_V = CW'(SKIP_LO);
      localparam logic [CW-1:0] HI_V = CW'(SKIP_HI);
      assign in_band = (off_cnt >= LO_V) && (off_cnt <= HI_V);
    end else begin : g_noskip
      assign in_band = 1'b0;
    end
  endgenerate

  assign want     = pend_q | req_raw;
  assign clear_ok = !busy && (off_cnt >= OFF_V) && (per_cnt >= PER_V) && !in_band;
  assign issue    = want & clear_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      req_pulse <= 1'b0;
    end else begin
      pend_q    <= want & ~clear_ok;
      req_pulse <= issue;
    end
  end

  pacer_sr_ctl u_sr (
    .clk(clk), .rst(rst), .set_i(edge_hit), .issue_i(issue),
    .ccm_mode(ccm_mode), .zc_neg(zc_neg), .sr_en(sr_en)
  );
endmodule

// File: rtl/req_pacer_chk.sv
module req_pacer_chk
  import pacer_pkg::*;
#(
  parameter int unsigned OFF_MIN    = 1,
  parameter int unsigned PERIOD_MIN = 1,
  parameter int unsigned ON_TIMEOUT = 2,
  parameter int unsigned SKIP_LO    = 1,
  parameter int unsigned SKIP_HI    = 1,
  parameter bit          SKIP_EN    = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic fwd_fall,
  input logic ccm_mode,
  input logic zc_neg,
  input logic req_pulse,
  input logic sr_en
);
  localparam int unsigned SAT =
    max_u(max_u(OFF_MIN, PERIOD_MIN), max_u(SKIP_HI + 1, ON_TIMEOUT)) + 2;

  int unsigned ps, oc;   // cycles since last pulse / since on-phase end (+1)
  logic lk, act, endv;

  always_comb begin
    act  = lk | req_pulse;
    endv = act & (fwd_fall | (!req_pulse && ps == ON_TIMEOUT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps <= SAT;
      oc <= SAT;
      lk <= 1'b0;
    end else begin
      ps <= req_pulse ? 1 : ((ps < SAT) ? ps + 1 : ps);
      oc <= endv ? 1 : ((oc < SAT) ? oc + 1 : oc);
      lk <= act & ~endv;
    end
  end

  assert_off_time_R1: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> oc > OFF_MIN);
  assert_rate_R2: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> ps >= PERIOD_MIN);
  assert_lockout_R3: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> !lk);
  generate
    if (SKIP_EN) begin : g_band
      assert_band_skip_R5: assert property (@(posedge clk) disable iff (rst)
        req_pulse |-> !((oc >= SKIP_LO + 1) && (oc <= SKIP_HI + 1)));
    end
  endgenerate
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    req_pulse |=> !req_pulse);
  assert_sr_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_en) |-> $past(fwd_fall));
  assert_sr_dcm_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (sr_en && !ccm_mode && zc_neg) |=> !sr_en);
  assert_sr_off_at_req_R10: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> !sr_en);
endmodule

bind req_pacer req_pacer_chk #(
  .OFF_MIN(OFF_MIN), .PERIOD_MIN(PERIOD_MIN), .ON_TIMEOUT(ON_TIMEOUT),
  .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI), .SKIP_EN(SKIP_EN)
) u_chk (
  .clk(clk), .rst(rst), .fwd_fall(fwd_fall), .ccm_mode(ccm_mode),
  .zc_neg(zc_neg), .req_pulse(req_pulse), .sr_en(sr_en)
);

// File: tb/sim_req_pacer.sv
module sim_req_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int OFF = 3;
  localparam int PER = 8;
  localparam int TO  = 20;
  localparam int LO  = 5;
  localparam int HI  = 7;
  localparam int ZD  = 2;   // zero-cross delay after forward edge

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_raw = 1'b0, fwd_fall = 1'b0, ccm_mode = 1'b0, zc_neg = 1'b0;
  logic req_pulse, sr_en;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  req_pacer #(
    .OFF_MIN(OFF), .PERIOD_MIN(PER), .ON_TIMEOUT(TO),
    .SKIP_LO(LO), .SKIP_HI(HI), .SKIP_EN(1'b1)
  ) u0 (
    .clk(clk), .rst(rst), .req_raw(req_raw), .fwd_fall(fwd_fall),
    .ccm_mode(ccm_mode), .zc_neg(zc_neg), .req_pulse(req_pulse), .sr_en(sr_en)
  );

  task automatic chk(input logic got, input logic exp, input string tag,
                     input string what, input int k, input int d, input int qo);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s k=%0d d=%0d qo=%0d actual=%0b expected=%0b",
               tag, what, k, d, qo, got, exp);
    end
  endtask

  // One request at idle (pulse P, k=0), forward edge sampled at P+d,
  // new raw request sampled at P+qo, zero cross at P+d+ZD.
  task automatic run_case(input int d, input int qo, input bit ccm);
    int e, x, srend;
    bit srset, banded;
    string ptag, stag;
    e = (d < TO) ? d : TO;                 // on-phase end: edge or timeout (R3, R4)
    x = qo;                                // pending request waits (R6)
    if (e + OFF > x) x = e + OFF;          // R1
    if (PER > x) x = PER;                  // R2
    banded = (x - e >= LO) && (x - e <= HI);
    if (banded) x = e + HI + 1;            // R5
    srset = (d <= TO);
    srend = x;
    if (!ccm && d + ZD < srend) srend = d + ZD;
    ccm_mode = ccm;
    @(negedge clk);
    req_raw = 1'b1;
    @(negedge clk);
    req_raw = 1'b0;
    for (int k = 0; k <= x + 2; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0)        ptag = "R7 R11";
      else if (banded)   ptag = "R5";
      else if (d > TO)   ptag = "R4";
      else if (qo < e)   ptag = "R3 R6";
      else               ptag = "R1 R2 R7";
      chk(req_pulse, (k == 0) || (k == x), ptag, "req_pulse", k, d, qo);
      if (srset && k == d)   stag = "R8";
      else if (d > TO)       stag = "R4";
      else if (ccm)          stag = "R10";
      else                   stag = "R9";
      chk(sr_en, srset && (k >= d) && (k < srend), stag, "sr_en", k, d, qo);
      fwd_fall = (k + 1 == d);
      req_raw  = (k + 1 == qo);
      zc_neg   = (k + 1 == d + ZD);
    end
    fwd_fall = 1'b0;
    req_raw  = 1'b0;
    zc_neg   = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state of outputs
    chk(req_pulse, 1'b0, "R11", "req_pulse after reset", 0, 0, 0);
    chk(sr_en, 1'b0, "R11", "sr_en after reset", 0, 0, 0);
    // R11: first request right after reset issues immediately
    run_case(4, 6, 1'b1);
    for (int m = 0; m < 2; m++) begin
      for (int d = 1; d <= TO + 2; d++) begin
        for (int qo = 1; qo <= ((d < TO) ? d : TO) + 10; qo++) begin
          run_case(d, qo, m[0]);
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule